// File: doc/BRIEF.md
# Wired Reset Arbiter for Shared Open-Collector Link Lines

This block sits in the programmable logic of a board that shares several open-collector link lines with neighbouring boards. Each line idles high through a pull-up, and any board may pull it low to request a reset or to signal a synchronization event. An internal request from the board's own logic can start the same event.

The arbiter samples every line level and the internal request through a synchronizer. It picks the first source to assert, asserts the board reset, and pulls down lines through per-line drive-enables. A high drive-enable turns on an external transistor that pulls that line low. A controlling link line is never driven by this board, so it cannot hold itself low. After the controlling source lets go, the arbiter drops its drives. It accepts no new request until every line reads high again, because another board may still be holding one low.

Line 0 is the primary boot line. A status port shows the controlling source and whether the arbiter is busy.

Top module: `wired_reset_arbiter`

## Requirements
- R1: After the asynchronous reset: `board_rst_o` is 0, every `drive_o` bit is 0 and `busy_o` is 0.
- R2: Each line and the internal request pass through a two-stage synchronizer. An input change made between clock edges reaches the outputs on the third rising edge after it, and not on the second.
- R3: While idle, if line k reads low (and the internal request does not win), the arbiter:
  - asserts `board_rst_o`;
  - sets `drive_o` to all ones except bit k, which stays 0;
  - reports `ctrl_idx_o` = k, `ctrl_int_o` = 0 and `busy_o` = 1.
- R4: While a link line controls, `board_rst_o` and `drive_o` are held, and the internal request has no effect on them. They are released only once the synchronized controlling line reads high.
- R5: While idle, if the internal request is high, the arbiter asserts `board_rst_o`, sets every `drive_o` bit including bit 0, and reports `ctrl_int_o` = 1.
- R6: While the internal request controls, `board_rst_o` and all drives are held until the synchronized request reads low, and then released.
- R7: After any release, the arbiter waits in a re-arm state and returns to idle only once every synchronized line reads high. In that state:
  - `board_rst_o` and `drive_o` are 0 and `busy_o` is 1;
  - a new line or internal request has no effect.
- R8: When several sources are seen in the same cycle while idle, the internal request wins. Among lines, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| line_i | input | N | Sensed level of each shared line (low = request) |
| int_req_i | input | 1 | Internal reset request, active high |
| drive_o | output | N | Per-line pull-down enable, 1 pulls the line low |
| board_rst_o | output | 1 | Board reset, active high |
| ctrl_idx_o | output | IW | Index of the controlling line |
| ctrl_int_o | output | 1 | 1 when the internal request is the controlling source |
| busy_o | output | 1 | 1 whenever the arbiter is not idle |

## Verification
The assertions assume that each line the block drives reads back low at its own input. They also assume that a release only happens once the controlling source's synchronized level has changed. Both hold only on a wired-AND line, which is how the bench models it: each sensed line is the complement of the block's own drive ORed with an external-board pull-down. All inputs change on the falling edge, so each synchronizer sees clean levels. Requests are held for at least three cycles, long enough for them to pass the synchronizer.

// File: rtl/wired_reset_arbiter.sv
module wired_reset_arbiter #(
  parameter int N           = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  line_i,
  input  logic          int_req_i,
  output logic [N-1:0]  drive_o,
  output logic          board_rst_o,
  output logic [IW-1:0] ctrl_idx_o,
  output logic          ctrl_int_o,
  output logic          busy_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD_LINK, ST_HOLD_INT, ST_REARM} state_t;

  localparam logic [N:0] SYNC_RST = {1'b0, {N{1'b1}}};

  logic [SYNC_STAGES-1:0][N:0] sync_q;
  logic [N-1:0]  line_s;
  logic          int_s;
  state_t        state_q, state_d;
  logic [IW-1:0] ctrl_idx_q, ctrl_idx_d;
  logic          ctrl_int_q, ctrl_int_d;
  logic [IW-1:0] first_idx;
  logic          any_low;
  logic [N-1:0]  own_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= SYNC_RST;
    end else begin
      sync_q[0] <= {int_req_i, line_i};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign line_s = sync_q[SYNC_STAGES-1][N-1:0];
  assign int_s  = sync_q[SYNC_STAGES-1][N];

  always_comb begin
    first_idx = '0;
    any_low   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!line_s[i]) begin
        first_idx = IW'(i);
        any_low   = 1'b1;
      end
    end
  end

  always_comb begin
    state_d    = state_q;
    ctrl_idx_d = ctrl_idx_q;
    ctrl_int_d = ctrl_int_q;
    unique case (state_q)
      ST_IDLE: begin
        if (int_s) begin
          state_d    = ST_HOLD_INT;
          ctrl_int_d = 1'b1;
        end else if (any_low) begin
          state_d    = ST_HOLD_LINK;
          ctrl_int_d = 1'b0;
          ctrl_idx_d = first_idx;
        end
      end
      ST_HOLD_LINK: if (line_s[ctrl_idx_q]) state_d = ST_REARM;
      ST_HOLD_INT:  if (!int_s)             state_d = ST_REARM;
      ST_REARM:     if (&line_s)            state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ctrl_idx_q <= '0;
      ctrl_int_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ctrl_idx_q <= ctrl_idx_d;
      ctrl_int_q <= ctrl_int_d;
    end
  end

  assign own_mask    = {{(N-1){1'b0}}, 1'b1} << ctrl_idx_q;
  assign drive_o     = (state_q == ST_HOLD_INT)  ? {N{1'b1}} :
                       (state_q == ST_HOLD_LINK) ? ~own_mask : '0;
  assign board_rst_o = (state_q == ST_HOLD_INT) || (state_q == ST_HOLD_LINK);
  assign busy_o      = (state_q != ST_IDLE);
  assign ctrl_idx_o  = ctrl_idx_q;
  assign ctrl_int_o  = ctrl_int_q;

  a_r7_rearm_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_REARM && state_q == ST_IDLE) |-> $past(&line_s));

  a_r4_link_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_HOLD_LINK && state_q != ST_HOLD_LINK) |-> $past(line_s[ctrl_idx_q]));

  a_r6_int_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_HOLD_INT && state_q != ST_HOLD_INT) |-> !$past(int_s));

  a_r3_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (board_rst_o && $past(board_rst_o)) |-> ($stable(ctrl_idx_o) && $stable(ctrl_int_o)));

  a_r8_int_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && int_s) |=> (ctrl_int_o && board_rst_o));

endmodule

// File: tb/wired_reset_arbiter_tb_top.sv
module wired_reset_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ext_low = '0;
  logic          int_req = 1'b0;
  logic [N-1:0]  line_lvl;
  logic [N-1:0]  drive;
  logic          brst;
  logic [IW-1:0] cidx;
  logic          cint;
  logic          busy;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_lvl = ~(drive | ext_low);

  wired_reset_arbiter #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_lvl), .int_req_i(int_req),
    .drive_o(drive), .board_rst_o(brst), .ctrl_idx_o(cidx),
    .ctrl_int_o(cint), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 board_rst", 32'(brst), 0);
    chk("R1 drive", 32'(drive), 0);
    chk("R1 busy", 32'(busy), 0);
  endtask

  task automatic t_link(input int k);
    logic [N-1:0] exp_drv;
    exp_drv = ~(N'(1) << k);
    ext_low[k] = 1'b1;
    tick(2);
    chk("R2 not yet", 32'(brst), 0);
    tick(1);
    chk("R3 board_rst", 32'(brst), 1);
    chk("R3 drive", 32'(drive), 32'(exp_drv));
    chk("R3 ctrl_idx", 32'(cidx), 32'(k));
    chk("R3 ctrl_int", 32'(cint), 0);
    int_req = 1'b1;
    tick(5);
    chk("R4 int ignored drive", 32'(drive), 32'(exp_drv));
    chk("R4 int ignored ctrl", 32'(cint), 0);
    int_req = 1'b0;
    tick(3);
    ext_low[k] = 1'b0;
    tick(2);
    chk("R4 still held", 32'(brst), 1);
    tick(1);
    chk("R4 released rst", 32'(brst), 0);
    chk("R7 drive off", 32'(drive), 0);
    chk("R7 busy in rearm", 32'(busy), 1);
    tick(2);
    chk("R7 rearm lasting", 32'(busy), 1);
    tick(1);
    chk("R7 idle again", 32'(busy), 0);
  endtask

  task automatic t_int;
    int_req = 1'b1;
    tick(3);
    chk("R5 board_rst", 32'(brst), 1);
    chk("R5 drive all", 32'(drive), 32'({N{1'b1}}));
    chk("R5 ctrl_int", 32'(cint), 1);
    int_req = 1'b0;
    tick(2);
    chk("R6 still held", 32'(brst), 1);
    tick(1);
    chk("R6 released rst", 32'(brst), 0);
    chk("R6 released drive", 32'(drive), 0);
    tick(3);
    chk("R7 idle after int", 32'(busy), 0);
  endtask

  task automatic t_rearm_block;
    ext_low[2] = 1'b1;
    tick(3);
    chk("R3 ctrl line2", 32'(cidx), 2);
    ext_low[1] = 1'b1;
    ext_low[2] = 1'b0;
    tick(3);
    chk("R7 enter rearm", 32'(brst), 0);
    tick(10);
    chk("R7 held busy", 32'(busy), 1);
    chk("R7 no drive", 32'(drive), 0);
    int_req = 1'b1;
    tick(5);
    chk("R7 int ignored", 32'(brst), 0);
    chk("R7 int ignored drive", 32'(drive), 0);
    int_req = 1'b0;
    tick(3);
    ext_low[1] = 1'b0;
    tick(2);
    chk("R7 wait sync", 32'(busy), 1);
    tick(1);
    chk("R7 idle", 32'(busy), 0);
  endtask

  task automatic t_tie;
    ext_low = 4'b0110;
    int_req = 1'b1;
    tick(3);
    chk("R8 int wins", 32'(cint), 1);
    chk("R8 int drive", 32'(drive), 32'h0f);
    int_req = 1'b0;
    ext_low = '0;
    tick(6);
    chk("R8 idle", 32'(busy), 0);
    ext_low = 4'b1010;
    tick(3);
    chk("R8 lowest idx", 32'(cidx), 1);
    chk("R8 lowest drive", 32'(drive), 32'h0d);
    ext_low = '0;
    tick(6);
    chk("R8 idle end", 32'(busy), 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_link(0);
    t_link(3);
    t_int();
    t_rearm_block();
    t_tie();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule